// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the six interrupt-capable status flags of a UART and decides when each one is raised and when it drops. The transmitter, the receiver and the line monitors report what happened through one-cycle event pulses. A register bus reaches the block through four strobes: status read, status write, data read and data write. The block answers with a 32-bit status word and a single interrupt request that is gated by six enable bits.

Three flags are cleared by writing 0 to them. The transmit-empty flag is cleared by writing to the data register. The transfer-complete and idle flags use an ordered sequence. A status read that sees the flag set arms it. The data access that follows then clears the flag, as long as no status write came in between. After the idle flag has been reported, it stays locked until new receive data arrives. A single quiet period therefore raises the flag only once.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status word is 32'h0000_00C0 (transmit-empty at bit 7 and transfer-complete at bit 6 are set, all other bits are clear) and `irq` is 0.
- R2: Bit 9 (clear-to-send change) sets on the clock edge that samples `cts_line` different from its previous sampled value, but only while `cts_en` is 1. A status write with bit 9 equal to 0 clears it. The previous-value register resets to 1.
- R3: Bit 8 (break) sets on `ev_break`. A status write with bit 8 equal to 0 clears it.
- R4: Bit 7 (transmit empty) sets on `ev_shift_load` and clears on `bus_data_wr`. Status writes have no effect on it.
- R5: Bit 6 (transfer complete) sets on `ev_frame_done` only if bit 7 is already 1 at that edge.
- R6: Bit 6 clears when a status write has bit 6 equal to 0. It also clears on a data write that follows a status read which saw bit 6 set. A status write between the read and the data write cancels the sequence, and a data write with no preceding read leaves bit 6 unchanged.
- R7: Bit 5 (receive data ready) sets on `ev_rx_load`. It clears on `bus_data_rd`, or when a status write has bit 5 equal to 0.
- R8: Bit 4 (idle) sets on `ev_idle`. It clears only on a data read that follows a status read which saw bit 4 set. A status write between the two cancels the sequence, and status writes never clear it directly.
- R9: Once bit 4 has been set, further `ev_idle` pulses are ignored until `ev_rx_load` has occurred.
- R10: A status write with 1 in any bit changes nothing. Bits 31:10 and 3:0 always read 0.
- R11: When a flag's set event and a clearing access fall in the same cycle, the flag ends up set.
- R12: `irq` is the OR over the six flags of flag AND enable. `ie[5:0]` maps to status bits 9 down to 4, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_shift_load | input | 1 | Transmit holding data moved to shifter |
| ev_frame_done | input | 1 | Transmit frame finished |
| ev_rx_load | input | 1 | Received byte loaded into data register |
| ev_idle | input | 1 | Idle line detected |
| ev_break | input | 1 | Line break detected |
| cts_line | input | 1 | Synchronized clear-to-send line |
| cts_en | input | 1 | Enables clear-to-send change tracking |
| bus_stat_rd | input | 1 | Status register read strobe |
| bus_stat_wr | input | 1 | Status register write strobe |
| bus_data_rd | input | 1 | Data register read strobe |
| bus_data_wr | input | 1 | Data register write strobe |
| bus_wdata | input | STAT_W | Status write data |
| ie | input | 6 | Interrupt enables, [5]=bit 9 ... [0]=bit 4 |
| status | output | STAT_W | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
A hardware set pulse and a software clear can arrive for the same flag in the same cycle. The bench provokes this by raising the break, receive-load and shift-load events in the same cycle as a clearing status write, data read or data write. It then requires each of those flags to read 1 afterwards. In that same cycle, the bench expects the transfer-complete flag, which has no set pulse, to drop. The interrupt output is also swept across all 64 enable combinations for two different flag patterns.

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_shift_load,
  input  logic              ev_frame_done,
  input  logic              ev_rx_load,
  input  logic              ev_idle,
  input  logic              ev_break,
  input  logic              cts_line,
  input  logic              cts_en,
  input  logic              bus_stat_rd,
  input  logic              bus_stat_wr,
  input  logic              bus_data_rd,
  input  logic              bus_data_wr,
  input  logic [STAT_W-1:0] bus_wdata,
  input  logic [5:0]        ie,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam int PAD_W = STAT_W - 10;

  logic cts_q, f_cts, f_brk, f_txe, f_tc, f_rxne, f_idle;
  logic arm_tc, arm_idle, idle_lock;

  wire cts_set  = cts_en & (cts_line ^ cts_q);
  wire cts_clr  = bus_stat_wr & ~bus_wdata[9];
  wire brk_clr  = bus_stat_wr & ~bus_wdata[8];
  wire tc_set   = ev_frame_done & f_txe;
  wire tc_clr   = (bus_data_wr & arm_tc) | (bus_stat_wr & ~bus_wdata[6]);
  wire rxne_clr = bus_data_rd | (bus_stat_wr & ~bus_wdata[5]);
  wire idle_set = ev_idle & ~idle_lock;
  wire idle_clr = bus_data_rd & arm_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_q     <= 1'b1;
      f_cts     <= 1'b0;
      f_brk     <= 1'b0;
      f_txe     <= 1'b1;
      f_tc      <= 1'b1;
      f_rxne    <= 1'b0;
      f_idle    <= 1'b0;
      arm_tc    <= 1'b0;
      arm_idle  <= 1'b0;
      idle_lock <= 1'b0;
    end else begin
      cts_q  <= cts_line;
      f_cts  <= cts_set       | (f_cts  & ~cts_clr);
      f_brk  <= ev_break      | (f_brk  & ~brk_clr);
      f_txe  <= ev_shift_load | (f_txe  & ~bus_data_wr);
      f_tc   <= tc_set        | (f_tc   & ~tc_clr);
      f_rxne <= ev_rx_load    | (f_rxne & ~rxne_clr);
      f_idle <= idle_set      | (f_idle & ~idle_clr);

      if (bus_stat_wr)      arm_tc <= 1'b0;
      else if (bus_stat_rd) arm_tc <= f_tc;
      else if (bus_data_wr) arm_tc <= 1'b0;

      if (bus_stat_wr)      arm_idle <= 1'b0;
      else if (bus_stat_rd) arm_idle <= f_idle;
      else if (bus_data_rd) arm_idle <= 1'b0;

      if (idle_set)        idle_lock <= 1'b1;
      else if (ev_rx_load) idle_lock <= 1'b0;
    end
  end

  wire [5:0] flags = {f_cts, f_brk, f_txe, f_tc, f_rxne, f_idle};

  assign status = {{PAD_W{1'b0}}, flags, 4'b0000};
  assign irq    = |(flags & ie);
endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_shift_load,
  input logic              ev_rx_load,
  input logic              ev_break,
  input logic              cts_en,
  input logic              bus_data_wr,
  input logic [5:0]        ie,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  logic idle_q, idle_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      idle_ok <= 1'b1;
    end else begin
      idle_q <= status[4];
      if (ev_rx_load)               idle_ok <= 1'b1;
      else if (status[4] && !idle_q) idle_ok <= 1'b0;
    end
  end

  AST_CTS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_en |=> !$rose(status[9])); // R2
  AST_TXE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_wr && !ev_shift_load) |=> !status[7]); // R4
  AST_TC_AFTER_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(status[7])); // R5
  AST_RXNE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_load |=> status[5]); // R7
  AST_IDLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(idle_ok)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |=> status[8]); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 6'b0) |-> !irq); // R12
endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/uart_flag_ctrl_bench.sv
module uart_flag_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_shift_load = 0, ev_frame_done = 0, ev_rx_load = 0, ev_idle = 0, ev_break = 0;
  logic cts_line = 1'b1, cts_en = 1'b0;
  logic bus_stat_rd = 0, bus_stat_wr = 0, bus_data_rd = 0, bus_data_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [5:0]  ie = '0;
  logic [31:0] status;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_flag_ctrl u_uart_flag_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    {ev_shift_load, ev_frame_done, ev_rx_load, ev_idle, ev_break} = '0;
    {bus_stat_rd, bus_stat_wr, bus_data_rd, bus_data_wr} = '0;
    bus_wdata = '0;
  endtask

  task automatic sweep(input string tag, input logic [5:0] pat);
    for (int e = 0; e < 64; e++) begin
      ie = e[5:0];
      #1;
      chk(tag, {31'b0, irq}, {31'b0, |(pat & e[5:0])});
    end
    ie = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 32'h0C0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    bus_data_wr = 1; cyc();
    chk("R4 data write clears TXE; R6 unarmed TC kept", status, 32'h040);
    bus_stat_wr = 1; bus_wdata = 32'hFFFF_FFBF; cyc();
    chk("R6 write 0 clears TC", status, 32'h000);
    ev_frame_done = 1; cyc();
    chk("R5 no TC without TXE", status, 32'h000);
    ev_shift_load = 1; cyc();
    chk("R4 TXE set", status, 32'h080);
    ev_frame_done = 1; cyc();
    chk("R5 TC set with TXE", status, 32'h0C0);

    bus_stat_rd = 1; cyc();
    bus_data_wr = 1; cyc();
    chk("R6 read-then-write clears TC", status, 32'h000);
    ev_shift_load = 1; cyc();
    ev_frame_done = 1; cyc();
    bus_stat_rd = 1; cyc();
    bus_stat_wr = 1; bus_wdata = 32'hFFFF_FFFF; cyc();
    chk("R10 write ones no effect", status, 32'h0C0);
    bus_data_wr = 1; cyc();
    chk("R6 status write disarms TC", status, 32'h040);
    ev_shift_load = 1; cyc();

    ev_rx_load = 1; cyc();
    chk("R7 RXNE set", status, 32'h0E0);
    bus_data_rd = 1; cyc();
    chk("R7 data read clears RXNE", status, 32'h0C0);
    ev_rx_load = 1; cyc();
    bus_stat_wr = 1; bus_wdata = 32'hFFFF_FFDF; cyc();
    chk("R7 write 0 clears RXNE", status, 32'h0C0);

    ev_idle = 1; cyc();
    chk("R8 IDLE set", status, 32'h0D0);
    bus_stat_wr = 1; bus_wdata = 32'h0; cyc();
    chk("R8 status write leaves IDLE; R4 leaves TXE", status, 32'h090);
    ev_shift_load = 1; ev_frame_done = 1; cyc();
    ev_frame_done = 1; cyc();
    bus_stat_rd = 1; cyc();
    bus_data_rd = 1; cyc();
    chk("R8 read-then-read clears IDLE", status, 32'h0C0);
    ev_idle = 1; cyc();
    chk("R9 IDLE locked", status, 32'h0C0);
    ev_rx_load = 1; cyc();
    ev_idle = 1; cyc();
    chk("R9 IDLE unlocked after RXNE", status, 32'h0F0);
    bus_data_rd = 1; cyc();
    chk("R8 unarmed read keeps IDLE", status, 32'h0D0);
    bus_stat_rd = 1; cyc();
    bus_stat_wr = 1; bus_wdata = 32'hFFFF_FFFF; cyc();
    bus_data_rd = 1; cyc();
    chk("R8 status write disarms IDLE", status, 32'h0D0);
    bus_stat_rd = 1; cyc();
    bus_data_rd = 1; cyc();
    chk("R8 IDLE cleared", status, 32'h0C0);

    cts_line = 1'b0; cyc();
    chk("R2 toggle ignored when disabled", status, 32'h0C0);
    cts_en = 1'b1; cts_line = 1'b1; cyc();
    chk("R2 CTS set on toggle", status, 32'h2C0);
    bus_stat_wr = 1; bus_wdata = 32'hFFFF_FDFF; cyc();
    chk("R2 write 0 clears CTS", status, 32'h0C0);
    cyc();
    chk("R2 no set without toggle", status, 32'h0C0);

    ev_break = 1; cyc();
    chk("R3 break set", status, 32'h1C0);
    bus_stat_wr = 1; bus_wdata = 32'hFFFF_FEFF; cyc();
    chk("R3 write 0 clears break", status, 32'h0C0);

    ev_break = 1; bus_stat_wr = 1; bus_wdata = 32'h0; cyc();
    chk("R11 break set beats write 0", status, 32'h180);
    ev_rx_load = 1; bus_data_rd = 1; cyc();
    chk("R11 RXNE set beats data read", status, 32'h1A0);
    ev_shift_load = 1; bus_data_wr = 1; cyc();
    chk("R11 TXE set beats data write", status, 32'h1A0);
    ev_idle = 1; cyc();
    chk("R10 reserved bits zero", status & 32'hFFFF_FC0F, 32'h0);

    sweep("R12 irq pattern A", 6'b011011);
    bus_stat_wr = 1; bus_wdata = 32'h0; cyc();
    chk("R12 pattern B status", status, 32'h090);
    sweep("R12 irq pattern B", 6'b001001);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule